// File: doc/BRIEF.md
# SPI Slave Hold-Pause Controller

This block gives an SPI slave the ability to pause a transfer in the middle without being deselected. A hold input, active low, is compared against the low phase of the serial clock. When hold is recognised, the block freezes the receive shift register, the transmit shift register and the bit counter. It also turns off the serial output enable. When hold is released, the transfer continues at the bit where it stopped. Deselecting the slave during a hold abandons the transfer and returns the block to standby.

All pins (serial clock, chip select, hold, data in) are sampled on the rising edge of a faster system clock `clk`. They are expected to be synchronised to that clock already. A serial-clock edge is found by comparing the current sample with the previous one. Data is received MSB first on rising serial-clock edges and transmitted MSB first, which fits SPI modes 0 and 3. Every complete word is reported with a one-cycle `rx_valid` pulse. Command decoding and memory access belong to the logic that uses this block.

Top module: `spi_hold_pause`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `hold_active`, `miso_oe` and `rx_valid` are 0.
- R2: When `cs_n` is 0 and `hold_n` is 0 in a `clk` cycle where `sck` is 0, `hold_active` is 1 after that `clk` edge.
- R3: If `hold_n` falls while `sck` is 1, `hold_active` stays 0 as long as `sck` stays 1. It becomes 1 after the first `clk` edge that samples `sck` at 0 with `hold_n` still 0.
- R4: If `hold_n` rises while `sck` is 1, `hold_active` stays 1 until the first `clk` edge that samples `sck` at 0. If `hold_n` rises while `sck` is 0, hold ends after that `clk` edge.
- R5: A `clk` edge that samples `cs_n` at 1 clears `hold_active` and resets the bit position to the start of a word. The next selection then receives a fresh word of DATA_W bits.
- R6: `hold_active` is never 1 in the cycle after `cs_n` was sampled at 1.
- R7: `miso_oe` is 1 exactly when the last `clk` edge saw `cs_n` at 0 and left `hold_active` at 0. It is 0 in every cycle where `hold_active` is 1.
- R8: During hold, `sck` edges and `mosi` have no effect. The word received across a hold holds only the bits sampled outside the hold, and `miso` keeps its value.
- R9: The bit count is kept across a hold. A word completes after exactly DATA_W rising `sck` edges that were not held, whether or not a hold came in between.
- R10: Bits are received MSB first on rising `sck` edges. `rx_valid` pulses for one cycle, and `rx_data` holds the word, after the `clk` edge that detects the DATA_W-th rising edge.
- R11: `miso` shows bit DATA_W-1 of `tx_data`, loaded while deselected or at the end of a word. It shifts toward the MSB on each falling `sck` edge that comes after the first rising edge of the word, unless held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | Serial clock sample |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Hold request, active low |
| mosi | input | 1 | Serial data in |
| tx_data | input | DATA_W | Word to transmit next |
| miso | output | 1 | Serial data out value |
| miso_oe | output | 1 | Output enable for miso (0 = high impedance) |
| hold_active | output | 1 | Transfer is currently paused |
| rx_data | output | DATA_W | Last complete received word |
| rx_valid | output | 1 | One-cycle pulse when rx_data is new |

## Verification
Some rules are checked by the assertions in every cycle. Hold only starts when the clock is low. Hold only ends when the clock is low or the slave is deselected. Deselection always clears hold. The output enable is off during hold. The bit counter and the transmit register stay unchanged while held. A completed word leaves the counter at zero. Only the bench scenarios can show the data results: the bits received across a hold, a hold edge that arrives during clock-high and waits, and a word started again from scratch after an abandoned transfer. These are shown by comparing received words and `miso` against values the bench computes.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef struct packed {
        logic prev;
    } edge_state_t;

    typedef struct packed {
        logic held;
        logic oe;
    } gate_state_t;

endpackage

// File: rtl/spi_hold_edge.sv
module spi_hold_edge
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic sck_rise,
    output logic sck_fall,
    output logic sck_low
);

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sck;
        sck_rise  = sck & ~st_q.prev;
        sck_fall  = ~sck & st_q.prev;
        sck_low   = ~sck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic hold_n,
    input  logic sck_low,
    output logic held,
    output logic out_en
);

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d.held = 1'b0;
        end else if (sck_low) begin
            st_d.held = ~hold_n;
        end
        st_d.oe = ~cs_n & ~st_d.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held   = st_q.held;
    assign out_en = st_q.oe;

    a_r6_no_hold_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !st_q.held);

    a_r3_entry_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.held) |-> $past(sck_low) && !$past(hold_n));

    a_r4_exit_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.held) |-> $past(sck_low) || $past(cs_n));

endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              held,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rx_sr;
        logic [DATA_W-1:0] tx_sr;
        logic [DATA_W-1:0] rx_word;
        logic              valid;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic [DATA_W-1:0] rx_next;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        rx_next    = {st_q.rx_sr[DATA_W-2:0], mosi};
        if (!active) begin
            st_d.cnt   = '0;
            st_d.rx_sr = '0;
            st_d.tx_sr = tx_data;
        end else if (!held) begin
            if (sck_rise) begin
                st_d.rx_sr = rx_next;
                if (st_q.cnt == LAST_BIT) begin
                    st_d.cnt     = '0;
                    st_d.valid   = 1'b1;
                    st_d.rx_word = rx_next;
                    st_d.tx_sr   = tx_data;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (sck_fall && st_q.cnt != '0) begin
                st_d.tx_sr = {st_q.tx_sr[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso     = st_q.tx_sr[DATA_W-1];
    assign rx_data  = st_q.rx_word;
    assign rx_valid = st_q.valid;

    a_r9_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        held && active |=> $stable(st_q.cnt));

    a_r8_tx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        held && active |=> $stable(st_q.tx_sr));

    a_r10_word_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> st_q.cnt == '0);

endmodule

// File: rtl/spi_hold_pause.sv
module spi_hold_pause #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              hold_n,
    input  logic              mosi,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso,
    output logic              miso_oe,
    output logic              hold_active,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    logic sck_rise, sck_fall, sck_low;
    logic held, out_en;

    spi_hold_edge i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sck_low  (sck_low)
    );

    spi_hold_gate i_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .hold_n  (hold_n),
        .sck_low (sck_low),
        .held    (held),
        .out_en  (out_en)
    );

    spi_hold_shift #(.DATA_W(DATA_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (~cs_n),
        .held     (held),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi     (mosi),
        .tx_data  (tx_data),
        .miso     (miso),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    assign hold_active = held;
    assign miso_oe     = out_en;

    a_r7_oe_off_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> !miso_oe);

    a_r5_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !miso_oe && !rx_valid);

endmodule

// File: tb/test_spi_hold_pause.sv
`timescale 1ns/1ps
module test_spi_hold_pause;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, mosi = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic miso, miso_oe, hold_active, rx_valid;
    logic [W-1:0] rx_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    logic m_prev, m_held, m_oe, m_valid;
    int   m_cnt;
    logic [W-1:0] m_rx, m_tx, m_data;
    bit   model_on = 0;

    spi_hold_pause #(.DATA_W(W)) i_spi_hold_pause (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
        .mosi(mosi), .tx_data(tx_data), .miso(miso), .miso_oe(miso_oe),
        .hold_active(hold_active), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    always #2.5 clk = ~clk;

    function automatic logic exp_held(logic c, logic s, logic h, logic cur);
        if (c) return 1'b0;
        if (!s) return ~h;
        return cur;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_prev = 0; m_held = 0; m_oe = 0; m_valid = 0;
        m_cnt = 0; m_rx = '0; m_tx = '0; m_data = '0;
    endtask

    task automatic model_step();
        logic rise, fall, nh;
        logic [W-1:0] nxt;
        rise = sck & ~m_prev;
        fall = ~sck & m_prev;
        nh = exp_held(cs_n, sck, hold_n, m_held);
        m_valid = 0;
        if (cs_n) begin
            m_cnt = 0; m_rx = '0; m_tx = tx_data;
        end else if (!m_held) begin
            if (rise) begin
                nxt = {m_rx[W-2:0], mosi};
                m_rx = nxt;
                if (m_cnt == W-1) begin
                    m_cnt = 0; m_valid = 1; m_data = nxt; m_tx = tx_data;
                end else m_cnt++;
            end else if (fall && m_cnt != 0) begin
                m_tx = {m_tx[W-2:0], 1'b0};
            end
        end
        m_held = nh;
        m_oe = ~cs_n & ~nh;
        m_prev = sck;
    endtask

    task automatic tick();
        if (model_on) model_step();
        @(posedge clk);
        #1;
        if (model_on) begin
            chk("R2 hold_active vs model", W'(hold_active), W'(m_held));
            chk("R7 miso_oe vs model", W'(miso_oe), W'(m_oe));
            chk("R10 rx_valid vs model", W'(rx_valid), W'(m_valid));
            if (m_valid) chk("R8 rx_data vs model", rx_data, m_data);
            if (m_oe) chk("R11 miso vs model", W'(miso), W'(m_tx[W-1]));
        end
    endtask

    // one bit: low phase with data, then rising edge; returns valid seen at the rise
    task automatic one_bit(logic b, output logic v, output logic [W-1:0] d);
        mosi = b; sck = 0; tick();
        sck = 1; tick();
        v = rx_valid; d = rx_data;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic v;
        logic [W-1:0] d;
        logic [W-1:0] byte_v;
        logic m0;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);

        // R1 reset
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 hold_active in reset", W'(hold_active), 0);
        chk("R1 miso_oe in reset", W'(miso_oe), 0);
        chk("R1 rx_valid in reset", W'(rx_valid), 0);
        rst_n = 1;
        model_on = 1;
        tick();
        chk("R1 hold_active after reset", W'(hold_active), 0);

        // R6: hold request while deselected has no effect
        hold_n = 0; sck = 0; tick(); tick();
        chk("R6 no hold while deselected", W'(hold_active), 0);
        hold_n = 1;

        // R3: falling hold during clock-high is deferred
        tx_data = 8'hB6; tick();
        sck = 1; tick();
        cs_n = 0; tick();
        chk("R7 oe on when selected", W'(miso_oe), 1);
        chk("R11 first miso bit", W'(miso), 1);
        hold_n = 0; tick(); tick();
        chk("R3 deferred while sck high", W'(hold_active), 0);
        sck = 0; tick();
        chk("R3 hold after sck low", W'(hold_active), 1);
        chk("R7 oe off in hold", W'(miso_oe), 0);
        // R4 release during low takes effect at once
        hold_n = 1; tick();
        chk("R4 release in low", W'(hold_active), 0);

        // R8 and R9: byte 0xA5 with a hold after 3 bits and garbage clocks
        byte_v = 8'hA5;
        for (int i = W-1; i >= W-3; i--) one_bit(byte_v[i], v, d);
        sck = 0; hold_n = 0; tick();
        chk("R2 hold entry in low", W'(hold_active), 1);
        m0 = miso;
        for (int k = 0; k < 4; k++) begin
            mosi = k[0]; sck = 1; tick(); sck = 0; tick();
            chk("R8 no word during hold", W'(rx_valid), 0);
            chk("R8 miso frozen", W'(miso), W'(m0));
        end
        sck = 1; tick();
        hold_n = 1; tick();
        chk("R4 release deferred in high", W'(hold_active), 1);
        sck = 0; tick();
        chk("R4 release at next low", W'(hold_active), 0);
        for (int i = W-4; i >= 1; i--) begin
            one_bit(byte_v[i], v, d);
            chk("R9 no early word", W'(v), 0);
        end
        one_bit(byte_v[0], v, d);
        chk("R9 word after W unheld rises", W'(v), 1);
        chk("R10 word data across hold", d, 8'hA5);
        sck = 0; tick();
        chk("R10 valid is one cycle", W'(rx_valid), 0);

        // R5: deselect during hold abandons the word
        one_bit(1'b1, v, d); one_bit(1'b1, v, d);
        sck = 0; hold_n = 0; tick();
        chk("R2 hold before abandon", W'(hold_active), 1);
        cs_n = 1; tick();
        chk("R5 deselect clears hold", W'(hold_active), 0);
        chk("R5 deselect oe off", W'(miso_oe), 0);
        hold_n = 1; tick();
        cs_n = 0; tick();
        byte_v = 8'h3C;
        for (int i = W-1; i >= 0; i--) one_bit(byte_v[i], v, d);
        chk("R5 fresh word valid", W'(v), 1);
        chk("R5 fresh word data", d, 8'h3C);
        sck = 0; tick();

        // constrained random against the model
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(99) < 50) sck = ~sck;
            if ($urandom_range(99) < 8) hold_n = ~hold_n;
            if ($urandom_range(999) < 15) cs_n = ~cs_n;
            mosi = 1'($urandom);
            if (cs_n) tx_data = W'($urandom);
            tick();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule